// File: doc/BRIEF.md
# Instruction Length and Skip Unit

This unit looks at the first word of a 16-bit instruction and works out how many words the whole instruction takes, from one to three. The count depends on the operand codes held in the word. It also handles the skip that follows a failed conditional test. When the comparison stage reports a failed test, the unit enters a skipping state. In that state every fetched instruction is squashed: its execute enable is held low, so no operand side effects such as stack pointer moves take place. The program counter only steps past the instruction by its decoded length.

While skipping, each conditional that is skipped extends the skip by one more instruction and adds one cycle to a penalty count. The first non-conditional that is skipped ends the state. The word after it executes normally. The penalty count starts at one for the failed test itself and saturates at its largest value.

Top module: `instr_len_skip`

## Requirements
- R1: The word is split as opcode in bits [4:0], operand b in bits [9:5] and operand a in bits [15:10]. For a word with a nonzero opcode, `word_count` is 1, plus 1 if operand a needs an extra word, plus 1 if operand b needs an extra word.
- R2: A word whose bits [4:0] are zero has `word_count` equal to 1 plus the extra word of operand a only. Bits [9:5] never add a word in this case.
- R3: Operand codes 0x10 to 0x17, 0x1a, 0x1e and 0x1f each need one extra word. Every other code needs none, including the short literal codes 0x20 to 0x3f.
- R4: `pc_step` equals `word_count` when `fetch_valid` is high, and 0 otherwise, whether or not the unit is skipping.
- R5: When `test_failed` is high at a clock edge while the unit is not skipping, `skipping` is high after that edge and `penalty` is 1.
- R6: While `skipping` is high, `exec_en` is low. A skipped word with `fetch_valid` high and an opcode (bits [4:0]) from 0x10 to 0x17 keeps `skipping` high and raises `penalty` by 1.
- R7: A skipped word with `fetch_valid` high and a non-conditional opcode clears `skipping` after that edge. A word with bits [4:0] zero counts as non-conditional. `penalty` keeps its value, and the next valid word has `exec_en` high.
- R8: `test_failed` while `skipping` is high changes neither `skipping` nor `penalty`.
- R9: After a cycle with `rst` high, `skipping` is 0 and `penalty` is 0, even in the middle of a skip.
- R10: `penalty` saturates at its largest value (15 with `PEN_W` = 4) during long chains of skipped conditionals.
- R11: When not skipping, `exec_en` follows `fetch_valid`.
- R12: Cycles with `fetch_valid` low while skipping leave `skipping` and `penalty` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A new instruction first word is presented this cycle |
| fetch_word | input | 16 | First word of the presented instruction |
| test_failed | input | 1 | One-cycle strobe: the executing conditional failed its test |
| word_count | output | 2 | Decoded instruction length in words (1 to 3) |
| skipping | output | 1 | Skip state is active |
| pc_step | output | 2 | Words to advance the program counter this cycle |
| exec_en | output | 1 | The presented instruction may execute and apply side effects |
| penalty | output | PEN_W | Extra cycles spent by the latest failed test and its chained skips |

## Verification
The assertions assume that `test_failed` arrives only as a strobe from the comparison stage, and that `fetch_word` is meaningful only while `fetch_valid` is high. They check skip entry, chain extension, exit, idle hold and penalty saturation purely in terms of those inputs. The stimulus raises `test_failed` on cycles of its own, with `fetch_valid` low, except where R8 deliberately pulses it during a skip. It holds `fetch_word` steady through each driven cycle and changes it only just after an edge, so the decoded conditional flag the assertions rely on is stable at every sampling edge.

// File: rtl/ilsu_pkg.sv
package ilsu_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 5;
    localparam int OPB_W  = 5;
    localparam int OPA_W  = 6;
    localparam int LEN_W  = 2;

    // Field order is behaviour: a in [15:10], b in [9:5], opcode in [4:0]
    typedef struct packed {
        logic [OPA_W-1:0] opa;
        logic [OPB_W-1:0] opb;
        logic [OPC_W-1:0] opc;
    } instr_fields_t;

    typedef struct packed {
        logic             special;
        logic             cond;
        logic [LEN_W-1:0] len;
    } decode_t;

    localparam logic [OPC_W-1:0] COND_LO = 5'h10;
    localparam logic [OPC_W-1:0] COND_HI = 5'h17;

    // Does this operand code pull one word from the instruction stream?
    function automatic logic needs_word(input logic [OPA_W-1:0] code);
        logic indexed;
        indexed = (code >= 6'h10) && (code <= 6'h17);
        return indexed || (code == 6'h1a) || (code == 6'h1e) || (code == 6'h1f);
    endfunction

    function automatic logic is_cond_op(input logic [OPC_W-1:0] opc);
        return (opc >= COND_LO) && (opc <= COND_HI);
    endfunction

endpackage

// File: rtl/ilsu_decode.sv
module ilsu_decode
    import ilsu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output decode_t           dec
);
    instr_fields_t f;
    logic          ext_a;
    logic          ext_b;

    always_comb begin
        f            = instr_fields_t'(word);
        dec.special  = (f.opc == '0);
        ext_a        = needs_word(f.opa);
        ext_b        = needs_word({1'b0, f.opb}) && !dec.special;
        dec.cond     = !dec.special && is_cond_op(f.opc);
        dec.len      = LEN_W'(1) + LEN_W'(ext_a) + LEN_W'(ext_b);
    end

    always_comb begin
        AST_LEN_NONZERO: assert (dec.len != '0); // R1
    end
endmodule

// File: rtl/ilsu_skip_ctrl.sv
module ilsu_skip_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic fetch_valid,
    input  logic word_is_cond,
    input  logic test_failed,
    output logic skipping,
    output logic pen_load,
    output logic pen_inc
);
    logic skip_q;
    logic skip_d;

    always_comb begin
        skip_d   = skip_q;
        pen_load = 1'b0;
        pen_inc  = 1'b0;
        if (!skip_q) begin
            if (test_failed) begin
                skip_d   = 1'b1;
                pen_load = 1'b1;
            end
        end else if (fetch_valid) begin
            if (word_is_cond) begin
                pen_inc = 1'b1;
            end else begin
                skip_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) skip_q <= 1'b0;
        else     skip_q <= skip_d;
    end

    assign skipping = skip_q;

    AST_SKIP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!skip_q && test_failed) |=> skip_q); // R5
    AST_CHAIN_EXTEND: assert property (@(posedge clk) disable iff (rst)
        (skip_q && fetch_valid && word_is_cond) |=> skip_q); // R6
    AST_CHAIN_EXIT: assert property (@(posedge clk) disable iff (rst)
        (skip_q && fetch_valid && !word_is_cond) |=> !skip_q); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (skip_q && !fetch_valid) |=> skip_q); // R12
endmodule

// File: rtl/ilsu_penalty.sv
module ilsu_penalty #(
    parameter int PEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             inc,
    output logic [PEN_W-1:0] count
);
    localparam logic [PEN_W-1:0] PEN_MAX = {PEN_W{1'b1}};
    localparam logic [PEN_W-1:0] PEN_ONE = PEN_W'(1);

    logic [PEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                         cnt_q <= '0;
        else if (load)                   cnt_q <= PEN_ONE;
        else if (inc && cnt_q != PEN_MAX) cnt_q <= cnt_q + PEN_ONE;
    end

    assign count = cnt_q;

    AST_PEN_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == PEN_ONE)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!load && inc && cnt_q == PEN_MAX) |=> (cnt_q == PEN_MAX)); // R10
    AST_PEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/instr_len_skip.sv
module instr_len_skip
    import ilsu_pkg::*;
#(
    parameter int PEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [15:0]      fetch_word,
    input  logic             test_failed,
    output logic [1:0]       word_count,
    output logic             skipping,
    output logic [1:0]       pc_step,
    output logic             exec_en,
    output logic [PEN_W-1:0] penalty
);
    decode_t dec;
    logic    pen_load;
    logic    pen_inc;

    ilsu_decode u_decode (
        .word (fetch_word),
        .dec  (dec)
    );

    ilsu_skip_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .fetch_valid  (fetch_valid),
        .word_is_cond (dec.cond),
        .test_failed  (test_failed),
        .skipping     (skipping),
        .pen_load     (pen_load),
        .pen_inc      (pen_inc)
    );

    ilsu_penalty #(.PEN_W(PEN_W)) u_pen (
        .clk   (clk),
        .rst   (rst),
        .load  (pen_load),
        .inc   (pen_inc),
        .count (penalty)
    );

    assign word_count = dec.len;
    assign pc_step    = fetch_valid ? dec.len : 2'd0;
    assign exec_en    = fetch_valid && !skipping;

    AST_IGNORE_FAIL_IN_SKIP: assert property (@(posedge clk) disable iff (rst)
        (skipping && test_failed && !fetch_valid) |=> (skipping && $stable(penalty))); // R8
endmodule

// File: tb/test_instr_len_skip.sv
module test_instr_len_skip;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid;
    logic [15:0] fetch_word;
    logic        test_failed;
    logic [1:0]  word_count;
    logic        skipping;
    logic [1:0]  pc_step;
    logic        exec_en;
    logic [3:0]  penalty;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    instr_len_skip i_instr_len_skip (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .test_failed(test_failed), .word_count(word_count), .skipping(skipping),
        .pc_step(pc_step), .exec_en(exec_en), .penalty(penalty)
    );

    // {word, expected length}
    localparam logic [17:0] VEC [14] = '{
        {16'h0401, 2'd1},  // R1 registers only
        {16'h7FC1, 2'd3},  // R1 a=next literal, b=[next word]
        {16'h4002, 2'd2},  // R3 a=indexed 0x10
        {16'h8341, 2'd2},  // R3 a short literal, b=0x1a
        {16'hFEF2, 2'd2},  // R3 a=0x3f literal, b=0x17
        {16'h7C20, 2'd2},  // R2 special, a=0x1f
        {16'h03C0, 2'd1},  // R2 special, bits[9:5]=0x1e ignored
        {16'h0200, 2'd1},  // R2 special, bits[9:5]=0x10 ignored
        {16'h6301, 2'd1},  // R3 stack codes 0x18
        {16'h7A10, 2'd3},  // R1 cond with two extra words
        {16'h6761, 2'd1},  // R3 codes 0x19, 0x1b
        {16'h5FE3, 2'd3},  // R3 a=0x17, b=0x1f
        {16'h6940, 2'd2},  // R2 special a=0x1a
        {16'h3DEC, 2'd1}   // R3 codes 0x0f
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input logic [15:0] w, input logic tf);
        fetch_valid = v;
        fetch_word  = w;
        test_failed = tf;
        #1;
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 16'h0000, 1'b0);
        step(); step();
        rst = 1'b0;
        check("R9 reset skipping", int'(skipping), 0);
        check("R9 reset penalty", int'(penalty), 0);

        // Decode table
        foreach (VEC[i]) begin
            drive(1'b1, VEC[i][17:2], 1'b0);
            check("R1/R2/R3 word_count", int'(word_count), int'(VEC[i][1:0]));
            check("R4 pc_step valid", int'(pc_step), int'(VEC[i][1:0]));
            check("R11 exec_en", int'(exec_en), 1);
            drive(1'b0, VEC[i][17:2], 1'b0);
            check("R4 pc_step idle", int'(pc_step), 0);
            check("R11 exec_en idle", int'(exec_en), 0);
            step();
        end

        // Chain: fail, skip two conditionals, skip one plain
        drive(1'b0, 16'h0000, 1'b1);
        step();
        drive(1'b0, 16'h0000, 1'b0);
        check("R5 enter skip", int'(skipping), 1);
        check("R5 penalty one", int'(penalty), 1);
        step(); step(); step();
        check("R12 idle hold", int'(skipping), 1);
        check("R12 idle penalty", int'(penalty), 1);
        drive(1'b1, 16'h7FD3, 1'b0);
        check("R6 exec_en low", int'(exec_en), 0);
        check("R4 skip step 3", int'(pc_step), 3);
        step();
        check("R6 still skipping", int'(skipping), 1);
        check("R6 penalty 2", int'(penalty), 2);
        drive(1'b0, 16'h0000, 1'b1);
        step();
        check("R8 ignore fail skip", int'(skipping), 1);
        check("R8 ignore fail pen", int'(penalty), 2);
        drive(1'b1, 16'h0017, 1'b0);
        step();
        check("R6 op 0x17 cond", int'(penalty), 3);
        drive(1'b1, 16'h0200, 1'b0);
        check("R6 special exec_en", int'(exec_en), 0);
        check("R4 special step", int'(pc_step), 1);
        step();
        check("R7 special ends", int'(skipping), 0);
        check("R7 penalty kept", int'(penalty), 3);
        drive(1'b1, 16'h0401, 1'b0);
        check("R7 next executes", int'(exec_en), 1);
        step();

        // Opcode 0x18 is not conditional
        drive(1'b0, 16'h0000, 1'b1);
        step();
        drive(1'b1, 16'h0018, 1'b0);
        step();
        check("R7 op 0x18 ends", int'(skipping), 0);
        check("R7 op 0x18 pen", int'(penalty), 1);

        // Saturation
        drive(1'b0, 16'h0000, 1'b1);
        step();
        for (int k = 0; k < 20; k++) begin
            drive(1'b1, 16'h0010, 1'b0);
            step();
        end
        check("R10 saturate", int'(penalty), 15);
        check("R10 still skipping", int'(skipping), 1);

        // Reset mid-skip
        drive(1'b0, 16'h0000, 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R9 mid reset skip", int'(skipping), 0);
        check("R9 mid reset pen", int'(penalty), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule